// File: doc/BRIEF.md
# Preamble Control Header Inserter

This block sits in the byte-wide transmit path of a multi-port serial media link, on the side of the PHY that faces the MAC. Every frame enters as its eight lead-in bytes (seven preamble bytes and the start-of-frame delimiter) followed by the frame data. When insertion is enabled, the block overwrites those eight bytes with a structured header. The header holds a start byte, a control byte, a five-byte extension and a CRC-8 check byte. The extension can carry the nanoseconds part of an ingress timestamp, so the receiver gets it in-band. The seconds part is not carried.

Each frame takes its configuration (enable, subport number, extension type) and its 32-bit timestamp in the cycle that its first byte is presented. Those values hold for the whole frame, so a configuration change can only take effect at a frame boundary. When insertion is disabled, frames pass through unchanged. The output is the input stream delayed by one register stage.

The control unit is a two-state machine. ST_PASS forwards bytes unchanged. ST_HDR substitutes header bytes at lead-in positions 1 to 7. Its transitions are:

- **start_hdr**: a start-of-frame byte arrives with insertion enabled. It goes from either state to ST_HDR.
- **start_plain**: a start-of-frame byte arrives with insertion disabled. It goes from either state to ST_PASS.
- **hdr_done**: the check byte (position 7) is accepted. It goes from ST_HDR to ST_PASS.
- **hdr_step**: any other valid byte arrives in ST_HDR. The state stays ST_HDR and the position advances.

Top module: `preamble_hdr_inserter`

## Requirements
- R1: After reset, out_valid, out_sof and out_data are all 0.
- R2: Latency is one cycle.
  - out_valid and out_sof equal in_valid and in_sof of the previous cycle.
  - When out_valid is 0, out_data is 0.
- R3: On an enabled frame, output byte 0 is the START_BYTE parameter (default 0xFB).
- R4: On an enabled frame, output byte 1 is the control byte, laid out as follows.
  - Bits [7:6] are the type, always 00 (packet carrying a header).
  - Bits [5:2] are the subport.
  - Bits [1:0] are the extension type.
- R5: With extension type 01, bytes 2 to 6 carry the timestamp.
  - Byte 2 is 0x00.
  - Bytes 3 to 6 are the 32-bit timestamp, most significant byte first.
- R6: With extension type 00, 10 or 11, bytes 2 to 6 are 0x00.
- R7: Byte 7 is a CRC-8 over bytes 1 to 6, taken in order and MSB first.
  - The polynomial is x^8+x^2+x+1 and the initial value is 0.
  - There is no final inversion.
- R8: Data bytes from position 8 onward pass through unchanged. A frame started with insertion disabled passes through entirely unchanged.
- R9: The enable, subport, extension type and timestamp are sampled only with the start-of-frame byte. Later changes do not affect the current frame.
- R10: Cycles with in_valid low do not advance the header position. The header continues with the next valid byte.
- R11: A start-of-frame byte arriving inside a header restarts the header using the new frame's configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first lead-in byte of a frame |
| in_data | input | 8 | Input byte |
| cfg_enable | input | 1 | Header insertion enable, sampled at start of frame |
| cfg_subport | input | 4 | Subport number for the control byte |
| cfg_ext | input | 2 | Extension type for the control byte |
| ts_ns | input | 32 | Nanoseconds part of the ingress timestamp |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is the first byte of a frame |
| out_data | output | 8 | Output byte |

## Verification
The bench sweeps every combination of enable, extension type and subport 0 to 7, with a different timestamp for each frame. Each output byte is compared with a header that the bench builds arithmetically, including its own CRC-8. Comparing enabled and disabled frames separates substitution from pass-through. Comparing extension type 01 with the other codes separates timestamp filling from zero filling.

In every frame, the configuration and timestamp are inverted right after the start byte. This shows that the values are sampled only at the frame boundary. Idle gaps inside the header on odd subports show that the position does not advance on invalid cycles. A frame restarted inside its header shows that the header restarts with the new frame's settings.

// File: rtl/pch_pkg.sv
package pch_pkg;
    typedef enum logic {ST_PASS = 1'b0, ST_HDR = 1'b1} pch_state_t;

    localparam logic [1:0] TYPE_WITH_HDR = 2'b00;
    localparam logic [1:0] EXT_TS        = 2'b01;
    localparam logic [7:0] CRC_POLY      = 8'h07;
    localparam int         HDR_LEN       = 8;
    localparam int         BYTE_W        = 8;
endpackage

// File: rtl/pch_crc8.sv
module pch_crc8 #(
    parameter int DATA_W = 48
) (
    input  logic [DATA_W-1:0] data,
    output logic [7:0]        crc
);
    import pch_pkg::*;

    always_comb begin
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[7] ^ data[i];
            c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
        end
        crc = c;
    end
endmodule

// File: rtl/pch_hdr_builder.sv
module pch_hdr_builder #(
    parameter logic [7:0] START_BYTE = 8'hFB,
    parameter int         SUB_W      = 4,
    parameter int         TS_W       = 32
) (
    input  logic [SUB_W-1:0]                           subport,
    input  logic [1:0]                                 ext,
    input  logic [TS_W-1:0]                            ts,
    output logic [pch_pkg::HDR_LEN-1:0][pch_pkg::BYTE_W-1:0] hdr
);
    import pch_pkg::*;

    localparam int EXT_BYTES = HDR_LEN - 3;
    localparam int EXT_W     = EXT_BYTES * BYTE_W;
    localparam int CRC_IN_W  = BYTE_W + EXT_W;

    logic [BYTE_W-1:0]   ctrl;
    logic [EXT_W-1:0]    ext_field;
    logic [7:0]          crc;

    assign ctrl      = {TYPE_WITH_HDR, subport, ext};
    assign ext_field = (ext == EXT_TS) ? {{(EXT_W - TS_W){1'b0}}, ts} : '0;

    pch_crc8 #(.DATA_W(CRC_IN_W)) u_crc (
        .data ({ctrl, ext_field}),
        .crc  (crc)
    );

    assign hdr[0] = START_BYTE;
    assign hdr[1] = ctrl;
    generate
        for (genvar g = 0; g < EXT_BYTES; g++) begin : g_ext
            assign hdr[2+g] = ext_field[EXT_W-1-g*BYTE_W -: BYTE_W];
        end
    endgenerate
    assign hdr[HDR_LEN-1] = crc;
endmodule

// File: rtl/preamble_hdr_inserter.sv
module preamble_hdr_inserter #(
    parameter logic [7:0] START_BYTE = 8'hFB,
    parameter int         SUB_W      = 4,
    parameter int         TS_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    input  logic             cfg_enable,
    input  logic [SUB_W-1:0] cfg_subport,
    input  logic [1:0]       cfg_ext,
    input  logic [TS_W-1:0]  ts_ns,
    output logic             out_valid,
    output logic             out_sof,
    output logic [7:0]       out_data
);
    import pch_pkg::*;

    localparam int POS_W = $clog2(HDR_LEN);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(HDR_LEN - 1);

    pch_state_t       state, state_n;
    logic [POS_W-1:0] pos, pos_n;
    logic [SUB_W-1:0] lat_sub;
    logic [1:0]       lat_ext;
    logic [TS_W-1:0]  lat_ts;
    logic [HDR_LEN-1:0][BYTE_W-1:0] hdr;
    logic [7:0]       byte_n;
    logic             start_fr;

    assign start_fr = in_valid && in_sof;

    pch_hdr_builder #(.START_BYTE(START_BYTE), .SUB_W(SUB_W), .TS_W(TS_W)) u_build (
        .subport (lat_sub),
        .ext     (lat_ext),
        .ts      (lat_ts),
        .hdr     (hdr)
    );

    always_comb begin
        state_n = state;
        pos_n   = pos;
        if (start_fr) begin
            state_n = cfg_enable ? ST_HDR : ST_PASS;
            pos_n   = cfg_enable ? POS_W'(1) : '0;
        end else if (in_valid) begin
            unique case (state)
                ST_HDR: begin
                    if (pos == LAST_POS) begin
                        state_n = ST_PASS;
                        pos_n   = '0;
                    end else begin
                        pos_n = pos + POS_W'(1);
                    end
                end
                ST_PASS: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_PASS;
            pos     <= '0;
            lat_sub <= '0;
            lat_ext <= '0;
            lat_ts  <= '0;
        end else begin
            state <= state_n;
            pos   <= pos_n;
            if (start_fr) begin
                lat_sub <= cfg_subport;
                lat_ext <= cfg_ext;
                lat_ts  <= ts_ns;
            end
        end
    end

    always_comb begin
        byte_n = 8'h00;
        if (in_valid) begin
            if (start_fr) begin
                byte_n = cfg_enable ? START_BYTE : in_data;
            end else begin
                unique case (state)
                    ST_HDR:  byte_n = hdr[pos];
                    ST_PASS: byte_n = in_data;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= 8'h00;
        end else begin
            out_valid <= in_valid;
            out_sof   <= start_fr;
            out_data  <= byte_n;
        end
    end
endmodule

// File: rtl/preamble_hdr_inserter_chk.sv
module preamble_hdr_inserter_chk #(
    parameter logic [7:0] START_BYTE = 8'hFB
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sof,
    input logic [7:0] in_data,
    input logic       cfg_enable,
    input logic       out_valid,
    input logic       out_sof,
    input logic [7:0] out_data
);
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_sof_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> out_sof);
    assert_sof_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == 8'h00));
    assert_start_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && cfg_enable) |=> (out_data == START_BYTE));
    assert_plain_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !cfg_enable) |=> (out_data == $past(in_data)));
endmodule

bind preamble_hdr_inserter preamble_hdr_inserter_chk #(.START_BYTE(START_BYTE)) u_chk (.*);

// File: tb/preamble_hdr_inserter_test.sv
module preamble_hdr_inserter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        cfg_enable = 1'b0;
    logic [3:0]  cfg_subport = 4'h0;
    logic [1:0]  cfg_ext = 2'b00;
    logic [31:0] ts_ns = 32'h0;
    logic        out_valid, out_sof;
    logic [7:0]  out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    preamble_hdr_inserter uut (.*);

    function automatic logic [7:0] crc8_bytes(input logic [7:0] b [6]);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < 6; k++) begin
            c ^= b[k];
            for (int j = 0; j < 8; j++)
                c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [7:0] exp_hdr(input int i, input logic [3:0] sub,
                                           input logic [1:0] ext, input logic [31:0] ts);
        logic [7:0] b [6];
        b[0] = {2'b00, sub, ext};
        b[1] = 8'h00;
        for (int k = 0; k < 4; k++)
            b[2+k] = (ext == 2'b01) ? ts[31-8*k -: 8] : 8'h00;
        if (i == 0) return 8'hFB;
        if (i == 7) return crc8_bytes(b);
        return b[i-1];
    endfunction

    task automatic check(input logic ev, input logic es, input logic [7:0] ed, input string tag);
        checks++;
        if (out_valid !== ev || out_sof !== es || out_data !== ed) begin
            failures++;
            $display("FAIL %s: actual v=%b s=%b d=%02h expected v=%b s=%b d=%02h",
                     tag, out_valid, out_sof, out_data, ev, es, ed);
        end
    endtask

    task automatic step(input logic v, input logic s, input logic [7:0] d,
                        input logic ev, input logic es, input logic [7:0] ed, input string tag);
        @(negedge clk);
        in_valid = v; in_sof = s; in_data = d;
        @(posedge clk);
        #1;
        check(ev, es, ed, tag);
    endtask

    function automatic string hdr_tag(input int i, input logic en, input logic [1:0] ext);
        if (!en) return "R8 plain lead-in";
        if (i == 0) return "R3 start byte";
        if (i == 1) return "R4 control byte";
        if (i == 7) return "R7 check byte";
        return (ext == 2'b01) ? "R5 timestamp ext" : "R6 zero ext";
    endfunction

    task automatic send_frame(input logic en, input logic [3:0] sub, input logic [1:0] ext,
                              input logic [31:0] ts, input bit gap);
        logic [7:0] pre;
        cfg_enable = en; cfg_subport = sub; cfg_ext = ext; ts_ns = ts;
        for (int i = 0; i < 8; i++) begin
            pre = (i < 7) ? 8'h55 : 8'hD5;
            if (gap && i == 3)
                step(1'b0, 1'b0, 8'hAA, 1'b0, 1'b0, 8'h00, "R10 gap idle");
            step(1'b1, i == 0, pre, 1'b1, i == 0,
                 en ? exp_hdr(i, sub, ext, ts) : pre,
                 (gap && i == 3) ? "R10 after gap" : (i > 1 ? {hdr_tag(i, en, ext), " R9"} : hdr_tag(i, en, ext)));
            if (i == 0) begin
                cfg_enable = ~en; cfg_subport = ~sub; cfg_ext = ~ext; ts_ns = ~ts;
            end
        end
        for (int p = 0; p < 4; p++)
            step(1'b1, 1'b0, 8'(p * 37 + sub), 1'b1, 1'b0, 8'(p * 37 + sub), "R8 payload");
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R2 idle after frame");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, 1'b0, 8'h00, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        for (int e = 0; e < 2; e++)
            for (int x = 0; x < 4; x++)
                for (int s = 0; s < 8; s++)
                    send_frame(e[0], 4'(s), 2'(x),
                               32'h9E3779B1 * (e * 32 + x * 8 + s + 1), s[0]);

        // R11: restart inside header
        cfg_enable = 1'b1; cfg_subport = 4'd2; cfg_ext = 2'b01; ts_ns = 32'hA1B2C3D4;
        step(1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 8'hFB, "R11 first start");
        step(1'b1, 1'b0, 8'h55, 1'b1, 1'b0, exp_hdr(1, 4'd2, 2'b01, 32'hA1B2C3D4), "R11 first ctrl");
        step(1'b1, 1'b0, 8'h55, 1'b1, 1'b0, 8'h00, "R11 first reserved");
        send_frame(1'b1, 4'd5, 2'b01, 32'h01234567, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule